// File: doc/BRIEF.md
# Code-Keyed Phase-Flip Carrier Generator

This block is the transmit side of one track-circuit node. It takes one of four fixed spreading codes of 63 chips and sends it as a phase-keyed audio carrier. Each chip lasts one full carrier period. The carrier is produced by reading one stored sine period of 20 samples. When the chip is 0, the table is read from the opposite half of the period, which turns the carrier upside down. No multiplier is used. The result is a stream of 12-bit offset-binary samples for a downstream DAC.

The master clock runs at 45 MHz. A clock-enable divider sets the sample rate. In the low-carrier mode (5 kHz) it fires every 450 master cycles, and in the high-carrier mode (9 kHz) every 250. The carrier mode and the code selection are captured when the generator is enabled. The code repeats without a break for as long as the enable stays high. When the enable drops, the output returns to mid-scale.

Top module: `bpsk_modulator`

## Requirements
- R1: While `rstN` is low, `dacSample` is 2048 (mid-scale) and `sampleStb` is 0.
- R2: In the cycle after a clock edge that samples `enable` low, `dacSample` is 2048 and `sampleStb` is 0. They stay so until the generator runs again.
- R3: The divider ratio is N = `DIV_A` (default 450) when the captured mode is 0, and N = `DIV_B` (default 250) when it is 1. The first edge that samples `enable` high starts the run. The first new sample appears after the N-th edge that follows it. Every later sample follows N edges after the one before. Each new sample is marked by `sampleStb` high for exactly one cycle.
- R4: The table holds T[i] = round(2048 + 2047·sin(2πi/20)) for i = 0..19. When the current chip is 1, sample i of the period is T[i].
- R5: When the current chip is 0, sample i of the period is T[(i+10) mod 20], a 180° shift.
- R6: Each chip takes 20 consecutive samples. The chip index runs 0..62 and then returns to 0, so the output repeats every 1260 samples.
- R7: The base sequence has m[0]=1, m[1..5]=0 and m[n]=m[n-5] xor m[n-6]. Code k (k = `codeSel`, 0..3) has chip n equal to m[n] xor m[(9·(n+k)) mod 63].
- R8: `modeB` and `codeSel` are captured on the edge that starts a run. Changes to them during the run have no effect on the timing or the values of the samples.
- R9: Between strobes, `dacSample` holds its value.
- R10: Each new run starts again at chip 0, sample 0, whatever point the previous run had reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 45 MHz master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces mid-scale |
| modeB | input | 1 | Carrier mode: 0 = low carrier (DIV_A), 1 = high carrier (DIV_B) |
| codeSel | input | 2 | Index of the spreading code to transmit |
| dacSample | output | 12 | Offset-binary carrier sample |
| sampleStb | output | 1 | One-cycle pulse when dacSample takes a new value |

## Verification
The rarest states are the return of the chip index from 62 to 0, which comes only after 1260 samples, and the flip between chips of different value. At the default ratios, a full code period takes more than 300,000 master cycles. For this reason the bench sets the two divider ratios to 18 and 10, which keeps the same 9:5 relation, and runs complete code periods in both modes. Configuration is changed in the middle of a run. A run is also cut off part way through a code and then restarted, to show that the captured settings and the restart point behave as required.

// File: rtl/bpsk_mod_pkg.sv
package bpsk_mod_pkg;

  localparam int unsigned PERIOD_SAMPLES = 20;
  localparam int unsigned HALF_PERIOD    = PERIOD_SAMPLES / 2;
  localparam int unsigned IDX_W          = $clog2(PERIOD_SAMPLES);
  localparam int unsigned CODE_LEN       = 63;
  localparam int unsigned CHIP_W         = $clog2(CODE_LEN);
  localparam int unsigned CODE_COUNT     = 4;
  localparam int unsigned SEL_W          = $clog2(CODE_COUNT);
  localparam int unsigned SAMPLE_W       = 12;
  localparam logic [SAMPLE_W-1:0] MID_SCALE = SAMPLE_W'(2048);

  // Strobes from the sequencer to the sample path
  typedef struct packed {
    logic             clearOut;
    logic             loadSample;
    logic             invertPhase;
    logic [IDX_W-1:0] tableIdx;
  } ctrlStrobe_t;

  // Code k = base sequence xor its 9-fold decimation, shifted by k
  function automatic logic [CODE_LEN-1:0] kasamiRow(input int unsigned shift);
    logic [CODE_LEN-1:0] base;
    logic [CODE_LEN-1:0] row;
    base    = '0;
    base[0] = 1'b1;
    for (int n = 6; n < CODE_LEN; n++) base[n] = base[n-5] ^ base[n-6];
    for (int n = 0; n < CODE_LEN; n++)
      row[n] = base[n] ^ base[(9 * (n + shift)) % CODE_LEN];
    return row;
  endfunction

endpackage

// File: rtl/bpsk_code_rom.sv
module bpsk_code_rom
  import bpsk_mod_pkg::*;
(
  input  logic [SEL_W-1:0]  codeSel,
  input  logic [CHIP_W-1:0] chipIdx,
  output logic              chipBit
);

  logic [CODE_COUNT-1:0] rowBits;

  for (genvar k = 0; k < CODE_COUNT; k++) begin : gRow
    localparam logic [CODE_LEN-1:0] ROW = kasamiRow(k);
    assign rowBits[k] = ROW[chipIdx];
  end

  assign chipBit = rowBits[codeSel];

endmodule

// File: rtl/bpsk_mod_ctrl.sv
module bpsk_mod_ctrl
  import bpsk_mod_pkg::*;
#(
  parameter int unsigned DIV_A = 450,
  parameter int unsigned DIV_B = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        modeB,
  input  logic [SEL_W-1:0] codeSel,
  output ctrlStrobe_t strobes
);

  localparam int unsigned DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned CNT_W   = $clog2(DIV_MAX);
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(DIV_A - 1);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(DIV_B - 1);
  localparam logic [IDX_W-1:0] LAST_SAMPLE = IDX_W'(PERIOD_SAMPLES - 1);
  localparam logic [CHIP_W-1:0] LAST_CHIP  = CHIP_W'(CODE_LEN - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t            state;
  logic [CNT_W-1:0]  divCnt;
  logic [IDX_W-1:0]  sampIdx;
  logic [CHIP_W-1:0] chipIdx;
  logic              modeLat;
  logic [SEL_W-1:0]  selLat;
  logic              chipBit;
  logic              tick;
  logic [CNT_W-1:0]  divLast;

  bpsk_code_rom uRom (
    .codeSel (selLat),
    .chipIdx (chipIdx),
    .chipBit (chipBit)
  );

  assign divLast = modeLat ? LAST_B : LAST_A;
  assign tick    = (state == ST_RUN) && enable && (divCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      sampIdx <= '0;
      chipIdx <= '0;
      modeLat <= 1'b0;
      selLat  <= '0;
    end else if (!enable) begin
      state <= ST_IDLE;
    end else if (state == ST_IDLE) begin
      state   <= ST_RUN;
      modeLat <= modeB;
      selLat  <= codeSel;
      divCnt  <= '0;
      sampIdx <= '0;
      chipIdx <= '0;
    end else if (tick) begin
      divCnt <= '0;
      if (sampIdx == LAST_SAMPLE) begin
        sampIdx <= '0;
        chipIdx <= (chipIdx == LAST_CHIP) ? '0 : chipIdx + 1'b1;
      end else begin
        sampIdx <= sampIdx + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.clearOut    = !enable;
    strobes.loadSample  = tick;
    strobes.invertPhase = !chipBit;
    strobes.tableIdx    = sampIdx;
  end

endmodule

// File: rtl/bpsk_mod_datapath.sv
module bpsk_mod_datapath
  import bpsk_mod_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobes,
  output logic [SAMPLE_W-1:0] dacSample,
  output logic                sampleStb
);

  logic [IDX_W-1:0]    readIdx;
  logic [SAMPLE_W-1:0] tableVal;

  // Opposite half of the period gives the inverted carrier
  always_comb begin
    if (strobes.invertPhase)
      readIdx = (strobes.tableIdx >= IDX_W'(HALF_PERIOD))
                ? strobes.tableIdx - IDX_W'(HALF_PERIOD)
                : strobes.tableIdx + IDX_W'(HALF_PERIOD);
    else
      readIdx = strobes.tableIdx;
  end

  always_comb begin
    case (readIdx)
      5'd0:    tableVal = 12'd2048;
      5'd1:    tableVal = 12'd2681;
      5'd2:    tableVal = 12'd3251;
      5'd3:    tableVal = 12'd3704;
      5'd4:    tableVal = 12'd3995;
      5'd5:    tableVal = 12'd4095;
      5'd6:    tableVal = 12'd3995;
      5'd7:    tableVal = 12'd3704;
      5'd8:    tableVal = 12'd3251;
      5'd9:    tableVal = 12'd2681;
      5'd10:   tableVal = 12'd2048;
      5'd11:   tableVal = 12'd1415;
      5'd12:   tableVal = 12'd845;
      5'd13:   tableVal = 12'd392;
      5'd14:   tableVal = 12'd101;
      5'd15:   tableVal = 12'd1;
      5'd16:   tableVal = 12'd101;
      5'd17:   tableVal = 12'd392;
      5'd18:   tableVal = 12'd845;
      5'd19:   tableVal = 12'd1415;
      default: tableVal = MID_SCALE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacSample <= MID_SCALE;
      sampleStb <= 1'b0;
    end else if (strobes.clearOut) begin
      dacSample <= MID_SCALE;
      sampleStb <= 1'b0;
    end else if (strobes.loadSample) begin
      dacSample <= tableVal;
      sampleStb <= 1'b1;
    end else begin
      sampleStb <= 1'b0;
    end
  end

endmodule

// File: rtl/bpsk_modulator.sv
module bpsk_modulator
  import bpsk_mod_pkg::*;
#(
  parameter int unsigned DIV_A = 450,
  parameter int unsigned DIV_B = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        modeB,
  input  logic [1:0]  codeSel,
  output logic [11:0] dacSample,
  output logic        sampleStb
);

  ctrlStrobe_t strobes;

  bpsk_mod_ctrl #(.DIV_A(DIV_A), .DIV_B(DIV_B)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .modeB   (modeB),
    .codeSel (codeSel),
    .strobes (strobes)
  );

  bpsk_mod_datapath uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dacSample (dacSample),
    .sampleStb (sampleStb)
  );

endmodule

// File: rtl/bpsk_mod_checker.sv
module bpsk_mod_checker #(
  parameter int unsigned DIV_A = 450,
  parameter int unsigned DIV_B = 250
) (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        sampleStb,
  input logic [11:0] dacSample
);

  int unsigned gap;
  logic        seenStb;

  // Counter measures strobe spacing without a long $past window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap     <= 0;
      seenStb <= 1'b0;
    end else if (!enable) begin
      gap     <= 0;
      seenStb <= 1'b0;
    end else if (sampleStb) begin
      gap     <= 1;
      seenStb <= 1'b1;
    end else if (gap < 32'hFFFF_FFFF) begin
      gap <= gap + 1;
    end
  end

  assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && seenStb && enable) |-> (gap == DIV_A || gap == DIV_B));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

  assert_idle_midscale_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (dacSample == 12'd2048 && !sampleStb));

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !sampleStb) |-> $stable(dacSample));

endmodule

bind bpsk_modulator bpsk_mod_checker #(.DIV_A(DIV_A), .DIV_B(DIV_B)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .sampleStb (sampleStb),
  .dacSample (dacSample)
);

// File: tb/sim_bpsk_modulator.sv
`timescale 1ns/1ps
module sim_bpsk_modulator;

  localparam int DA = 18;
  localparam int DB = 10;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       modeB = 1'b0;
  logic [1:0] codeSel = 2'd0;
  logic [11:0] dacSample;
  logic       sampleStb;

  always #5 clk = ~clk;

  bpsk_modulator #(.DIV_A(DA), .DIV_B(DB)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .modeB(modeB),
    .codeSel(codeSel), .dacSample(dacSample), .sampleStb(sampleStb)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit started = 0;
  string phase = "R1";

  int tbl [20];
  bit codeBits [4][63];

  // Reference tables built from R4 and R7
  initial begin
    int m [$];
    for (int i = 0; i < 20; i++)
      tbl[i] = int'(2048.0 + 2047.0 * $sin(2.0 * 3.14159265358979 * i / 20.0));
    m.push_back(1);
    for (int i = 1; i < 6; i++) m.push_back(0);
    for (int n = 6; n < 63; n++) m.push_back(m[n-5] ^ m[n-6]);
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 63; n++)
        codeBits[k][n] = bit'(m[n] ^ m[(9 * (n + k)) % 63]);
  end

  // Behavioural reference, evaluated on each rising edge
  bit  mRun = 0;
  int  mCnt, mS, mC, mSel, mDac = 2048;
  bit  mMode, mStb = 0;
  string mTag = "R1";

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (!rstN) begin
      mRun = 0; mDac = 2048; mStb = 0; mTag = "R1";
    end else if (!enable) begin
      mRun = 0; mDac = 2048; mStb = 0; mTag = "R2";
    end else if (!mRun) begin
      mRun = 1; mMode = modeB; mSel = codeSel;
      mCnt = 0; mS = 0; mC = 0; mStb = 0; mTag = "R10";
    end else if (mCnt == (mMode ? DB : DA) - 1) begin
      bit b;
      b = codeBits[mSel][mC];
      mCnt = 0;
      mDac = b ? tbl[mS] : tbl[(mS + 10) % 20];
      mStb = 1;
      mTag = b ? "R4" : "R5";
      mS++;
      if (mS == 20) begin
        mS = 0;
        mC = (mC + 1) % 63;
      end
    end else begin
      mCnt++; mStb = 0; mTag = "R9";
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (started) begin
      bit bad;
      bad = 0;
      compared++;
      if (dacSample !== 12'(mDac)) begin
        $display("FAIL %s (phase %s) cycle %0d: dacSample actual %0d expected %0d",
                 mTag, phase, cycles, dacSample, mDac);
        bad = 1;
      end
      if (sampleStb !== mStb) begin
        $display("FAIL R3 (phase %s) cycle %0d: sampleStb actual %0b expected %0b",
                 phase, cycles, sampleStb, mStb);
        bad = 1;
      end
      if (bad) mismatched++;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    waitCycles(6);
    rstN = 1'b1;
    waitCycles(4);

    // R3 R4 R5 R6: low-carrier mode, code 0, full period plus wrap
    phase = "R6";
    modeB = 1'b0; codeSel = 2'd0; enable = 1'b1;
    waitCycles(1260 * DA + 40 * DA + 3);

    // R2: disable mid-code
    phase = "R2";
    enable = 1'b0;
    waitCycles(37);

    // R8: high-carrier mode, code 2, settings changed during the run
    phase = "R8";
    modeB = 1'b1; codeSel = 2'd2; enable = 1'b1;
    waitCycles(40 * DB + 7);
    modeB = 1'b0; codeSel = 2'd1;
    waitCycles(260 * DB);
    codeSel = 2'd3;
    waitCycles(50 * DB + 3);

    // R10 R7: drop enable part way, restart with code 3 over a full period
    phase = "R10";
    enable = 1'b0;
    waitCycles(1);
    modeB = 1'b1; codeSel = 2'd3; enable = 1'b1;
    waitCycles(1260 * DB + 25 * DB);

    // R7: code 1 in low-carrier mode
    phase = "R7";
    enable = 1'b0;
    waitCycles(3);
    modeB = 1'b0; codeSel = 2'd1; enable = 1'b1;
    waitCycles(150 * DA + 5);

    // R1: reset while running
    phase = "R1";
    rstN = 1'b0;
    waitCycles(5);
    rstN = 1'b1;
    phase = "R10";
    waitCycles(30 * DA);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
    mismatched++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule